// File: doc/BRIEF.md
# Shadow-Updated Phase-Accumulator PWM Channel

This block generates one pulse-width-modulated output from a single 32-bit control word. The output frequency comes from a phase accumulator: on every input clock a base-unit step is added to an accumulator of `UNIT_W` bits, so the output repeats every 2^UNIT_W / step clocks. The duty cycle comes from an 8-bit on-time divisor that is compared with the top 8 bits of the accumulator. The divisor is inverted: a larger value gives a shorter high time, following divisor = 255 - 255 x duty.

Software writes land in a shadow copy of the configuration. The values that actually drive the accumulator and the comparator (the active copy) change only after software sets a self-clearing update request. While the channel runs, the copy waits for the next accumulator wrap so that a period is never cut short. While it is stopped, the copy happens on the next clock. The channel runs only when its enable bit is set and an update has been taken since the last reset or disable. A plain enable with no update keeps the output low. Clearing the enable bit stops the output at once.

Top module: `frac_pwm`

## Requirements
- R1: After reset, `rd_data` reads 0, `pwm_out` is low, and the shadow fields, active fields, accumulator, pending update and update-taken flag are all cleared.
- R2: Control word layout: bit 31 is the enable, bit 30 is the update request, bits 7:0 are the on-time divisor, and bits 8 upward hold the base-unit step (`UNIT_W` bits, 16 by default, so bits 23:8). Written bits between the step field and bit 30 are ignored and read back as 0.
- R3: `rd_data` bits 29:0 return the shadow fields. Bit 30 reads 1 while an update request is pending. Bit 31 reads 1 only while the channel is actually running, meaning the enable bit is set and an update has been taken.
- R4: A write with bit 30 clear changes only the shadow copy. The period and duty seen at `pwm_out` stay as they were.
- R5: A pending update copies shadow to active on the next accumulator wrap while the channel runs, or on the next clock while it is stopped. Afterwards bit 30 reads 0.
- R6: Setting the enable bit when no update has been taken since reset or the last disable leaves `pwm_out` low, and bit 31 reads 0.
- R7: A write with bit 31 clear drives `pwm_out` low from the next cycle on, with no update request needed. It also withdraws the update-taken flag, so the next enable needs a new update.
- R8: While running, the accumulator advances by the active step every clock. For a step that divides 2^UNIT_W, the output period is 2^UNIT_W / step clocks. While stopped, the accumulator is held at 0.
- R9: While running, `pwm_out` is high exactly when the top 8 accumulator bits are greater than or equal to the active divisor. Divisor 0 gives a constant high, and with step 4096 a divisor of 255 gives no high cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the accumulator advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writes `wr_data` into the control word on this clock |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word read-back |
| pwm_out | output | 1 | Pulse-width-modulated output |

## Verification
The checker watches, on every cycle, the handshake rules. The active configuration changes only on an update event. An update taken while running always coincides with an accumulator wrap. The pending bit reads 0 after the copy. The output stays low while no update has been taken, and drops on the cycle after a disabling write. Period and duty are properties of many cycles, so only the bench scenarios can show them. These scenarios count high cycles and rising edges over whole periods for several steps and divisors. They also check that shadow-only writes leave those counts untouched, and that an enable needs a fresh update after each disable.

// File: rtl/frac_pwm_pkg.sv
package frac_pwm_pkg;
  localparam int REG_W     = 32;
  localparam int EN_POS    = 31;
  localparam int UPD_POS   = 30;
  localparam int DIV_W     = 8;
  localparam int UNIT_LSB  = 8;
  localparam int MAX_UNIT_W = 22;

  // number of unused control bits between the step field and the update bit
  function automatic int pad_bits(input int unit_w);
    return UPD_POS - UNIT_LSB - unit_w;
  endfunction

  // inverted duty rule: high while phase top is at or above the divisor
  function automatic logic duty_is_high(input logic [DIV_W-1:0] phase_top,
                                        input logic [DIV_W-1:0] divisor);
    return phase_top >= divisor;
  endfunction
endpackage

// File: rtl/frac_pwm_regs.sv
module frac_pwm_regs
  import frac_pwm_pkg::*;
#(
  parameter int UNIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              wrap_evt,
  output logic [UNIT_W-1:0] shadow_unit,
  output logic [DIV_W-1:0]  shadow_div,
  output logic [UNIT_W-1:0] act_unit,
  output logic [DIV_W-1:0]  act_div,
  output logic              upd_pend,
  output logic              seen,
  output logic              running,
  output logic              apply_evt
);
  localparam int PAD_W = pad_bits(UNIT_W);

  logic en_req;
  logic en_fall;

  assign running   = en_req & seen;
  assign apply_evt = upd_pend & (~running | wrap_evt);
  assign en_fall   = wr_en & ~wr_data[EN_POS] & en_req;

  generate
    if (PAD_W > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data[UPD_POS-1:UNIT_LSB+UNIT_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_unit <= '0;
      shadow_div  <= '0;
      en_req      <= 1'b0;
    end else if (wr_en) begin
      shadow_unit <= wr_data[UNIT_LSB +: UNIT_W];
      shadow_div  <= wr_data[DIV_W-1:0];
      en_req      <= wr_data[EN_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      upd_pend <= 1'b0;
    else if (wr_en && wr_data[UPD_POS])
      upd_pend <= 1'b1;
    else if (apply_evt)
      upd_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_unit <= '0;
      act_div  <= '0;
    end else if (apply_evt) begin
      act_unit <= shadow_unit;
      act_div  <= shadow_div;
    end
  end

  // disabling wins over a same-cycle update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen <= 1'b0;
    else if (en_fall)
      seen <= 1'b0;
    else if (apply_evt)
      seen <= 1'b1;
  end
endmodule

// File: rtl/frac_pwm_accum.sv
module frac_pwm_accum
  import frac_pwm_pkg::*;
#(
  parameter int UNIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [UNIT_W-1:0] step,
  output logic [DIV_W-1:0]  phase_top,
  output logic              wrap_evt
);
  logic [UNIT_W-1:0] phase;
  logic [UNIT_W:0]   sum;

  assign sum       = {1'b0, phase} + {1'b0, step};
  assign wrap_evt  = run & sum[UNIT_W];
  assign phase_top = phase[UNIT_W-1 -: DIV_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (!run)
      phase <= '0;
    else
      phase <= sum[UNIT_W-1:0];
  end
endmodule

// File: rtl/frac_pwm_cmp.sv
module frac_pwm_cmp
  import frac_pwm_pkg::*;
(
  input  logic             run,
  input  logic [DIV_W-1:0] phase_top,
  input  logic [DIV_W-1:0] divisor,
  output logic             pwm_out
);
  assign pwm_out = run & duty_is_high(phase_top, divisor);
endmodule

// File: rtl/frac_pwm.sv
module frac_pwm
  import frac_pwm_pkg::*;
#(
  parameter int UNIT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  localparam int PAD_W = pad_bits(UNIT_W);

  logic [UNIT_W-1:0] shadow_unit;
  logic [DIV_W-1:0]  shadow_div;
  logic [UNIT_W-1:0] act_unit;
  logic [DIV_W-1:0]  act_div;
  logic              upd_pend;
  logic              seen;
  logic              running;
  logic              apply_evt;
  logic              wrap_evt;
  logic [DIV_W-1:0]  phase_top;

  frac_pwm_regs #(.UNIT_W(UNIT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wrap_evt   (wrap_evt),
    .shadow_unit(shadow_unit),
    .shadow_div (shadow_div),
    .act_unit   (act_unit),
    .act_div    (act_div),
    .upd_pend   (upd_pend),
    .seen       (seen),
    .running    (running),
    .apply_evt  (apply_evt)
  );

  frac_pwm_accum #(.UNIT_W(UNIT_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (running),
    .step     (act_unit),
    .phase_top(phase_top),
    .wrap_evt (wrap_evt)
  );

  frac_pwm_cmp u_cmp (
    .run      (running),
    .phase_top(phase_top),
    .divisor  (act_div),
    .pwm_out  (pwm_out)
  );

  generate
    if (PAD_W > 0) begin : g_rd_pad
      assign rd_data = {running, upd_pend, {PAD_W{1'b0}}, shadow_unit, shadow_div};
    end else begin : g_rd_full
      assign rd_data = {running, upd_pend, shadow_unit, shadow_div};
    end
  endgenerate
endmodule

// File: rtl/frac_pwm_chk.sv
module frac_pwm_chk #(
  parameter int UNIT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              pwm_out,
  input logic              running,
  input logic              seen,
  input logic              apply_evt,
  input logic              wrap_evt,
  input logic [UNIT_W-1:0] act_unit,
  input logic [7:0]        act_div
);
  // R7
  disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[31]) |=> !pwm_out);

  // R6
  no_update_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !pwm_out);

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_evt |=> ($stable(act_unit) && $stable(act_div)));

  // R5
  apply_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_evt && running) |-> wrap_evt);

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_evt && !(wr_en && wr_data[30])) |=> !rd_data[30]);

  // R3
  run_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out |-> rd_data[31]);
endmodule

bind frac_pwm frac_pwm_chk #(.UNIT_W(UNIT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .pwm_out  (pwm_out),
  .running  (running),
  .seen     (seen),
  .apply_evt(apply_evt),
  .wrap_evt (wrap_evt),
  .act_unit (act_unit),
  .act_div  (act_div)
);

// File: tb/sim_frac_pwm.sv
`timescale 1ns/1ps
module sim_frac_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  frac_pwm #(.UNIT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2 layout: 31 enable, 30 update, 23:8 step, 7:0 divisor
  function automatic logic [31:0] word(input bit en, input bit upd,
                                       input int unit, input int dv);
    logic [31:0] w = '0;
    w[31]   = en;
    w[30]   = upd;
    w[23:8] = unit[15:0];
    w[7:0]  = dv[7:0];
    return w;
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sample n cycles at falling edges: high count and rising edges
  task automatic measure(input int n, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0;
    @(negedge clk);
    prev = pwm_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
  endtask

  // expected high cycles over n clocks, step dividing 65536, from R8/R9
  function automatic int exp_highs(input int unit, input int dv, input int n);
    int per = 65536 / unit;
    int h = 0;
    for (int k = 0; k < per; k++)
      if (((k * unit) >> 8) >= dv) h++;
    return h * (n / per);
  endfunction

  task automatic start(input int unit, input int dv);
    wr(word(1'b0, 1'b1, unit, dv));
    wr(word(1'b1, 1'b0, unit, dv));
    idle(3);
  endtask

  task automatic t_reset;
    check(rd_data == 32'h0, "R1 rd_data after reset", rd_data, 0);
    check(pwm_out == 1'b0, "R1 pwm_out after reset", pwm_out, 0);
  endtask

  task automatic t_enable_no_update;
    int h, r;
    wr(word(1'b1, 1'b0, 4096, 128));
    measure(48, h, r);
    check(h == 0, "R6 output low without update", h, 0);
    check(rd_data[31] == 1'b0, "R6 run flag without update", rd_data[31], 0);
    check(rd_data[29:0] == word(1'b0, 1'b0, 4096, 128), "R3 shadow readback",
          rd_data[29:0], word(1'b0, 1'b0, 4096, 128));
  endtask

  task automatic t_update_enable;
    int h, r;
    start(4096, 128);
    check(rd_data[31] == 1'b1, "R3 run flag after update+enable", rd_data[31], 1);
    check(rd_data[30] == 1'b0, "R5 pending cleared", rd_data[30], 0);
    measure(32, h, r);
    check(h == exp_highs(4096, 128, 32), "R9 duty div 128", h, exp_highs(4096, 128, 32));
  endtask

  task automatic t_shadow_hold;
    int h, r;
    wr(word(1'b1, 1'b0, 8192, 0));
    measure(32, h, r);
    check(h == exp_highs(4096, 128, 32), "R4 shadow-only write keeps duty", h,
          exp_highs(4096, 128, 32));
    check(r == 2, "R4 shadow-only write keeps period", r, 2);
  endtask

  task automatic t_duty(input int dv);
    int h, r;
    wr(word(1'b1, 1'b1, 4096, dv));
    check(rd_data[30] == 1'b1, "R5 pending visible before wrap", rd_data[30], 1);
    idle(40);
    check(rd_data[30] == 1'b0, "R5 pending cleared after wrap", rd_data[30], 0);
    measure(32, h, r);
    check(h == exp_highs(4096, dv, 32), $sformatf("R9 duty div %0d", dv), h,
          exp_highs(4096, dv, 32));
  endtask

  task automatic t_freq(input int unit, input int exp_rises);
    int h, r;
    wr(word(1'b1, 1'b1, unit, 128));
    idle(40);
    measure(64, h, r);
    check(r == exp_rises, $sformatf("R8 rising edges step %0d", unit), r, exp_rises);
  endtask

  task automatic t_ignored_bits;
    logic [31:0] w;
    w = word(1'b1, 1'b0, 4096, 64);
    w[29:24] = 6'h3f;
    wr(w);
    check(rd_data[29:24] == 6'h0, "R2 bits above step field read 0", rd_data[29:24], 0);
    check(rd_data[23:0] == w[23:0], "R2 step/divisor fields", rd_data[23:0], w[23:0]);
  endtask

  task automatic t_disable;
    int h, r;
    wr(word(1'b0, 1'b0, 4096, 0));
    check(pwm_out == 1'b0, "R7 low right after disable", pwm_out, 0);
    measure(40, h, r);
    check(h == 0, "R7 stays low while disabled", h, 0);
    check(rd_data[31] == 1'b0, "R7 run flag cleared", rd_data[31], 0);
  endtask

  task automatic t_reenable;
    int h, r;
    wr(word(1'b1, 1'b0, 4096, 0));
    measure(40, h, r);
    check(h == 0, "R7 re-enable needs new update", h, 0);
    wr(word(1'b1, 1'b1, 4096, 0));
    idle(3);
    measure(32, h, r);
    check(h == 32, "R9 divisor 0 always high", h, 32);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(rd_data == 32'h0, "R1 rd_data during reset", rd_data, 0);
    check(pwm_out == 1'b0, "R1 pwm_out during reset", pwm_out, 0);
    rst_n = 1'b1;
    idle(2);
    check(rd_data == 32'h0, "R1 rd_data after reset release", rd_data, 0);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_enable_no_update();
    t_update_enable();
    t_shadow_hold();
    t_duty(0);
    t_duty(200);
    t_duty(255);
    t_duty(64);
    t_freq(4096, 4);
    t_freq(8192, 8);
    t_freq(2048, 2);
    t_ignored_bits();
    t_disable();
    t_reenable();
    t_reset_mid();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule